// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers up to 64 device interrupt lines into one pending-request vector and fans them out to a fixed set of CPUs. Each CPU owns an enable mask. The block keeps a per-CPU summary vector equal to that mask ANDed with the pending vector. Each CPU's level interrupt output is the OR of its summary bits. Devices raise or drop a line with a strobe that carries the line number. Software uses a 64-bit-only register port to program the masks and to read the masks, summaries and pending vector.

Alongside the level outputs, the block produces one-cycle event pulses for each CPU and line. A post pulse means the line just became enabled-and-pending for that CPU, or was raised again while enabled. A clear pulse means it stopped being enabled-and-pending. Events come only from real state changes. A mask write that does not alter a CPU's enabled-and-pending set makes no events. A drop strobe for a line that is not pending changes nothing and only flags a spurious clear.

Top module: `irq_route_hub`

## Requirements
- R1: For every CPU c, the summary register of c always equals mask c AND the pending vector. It is updated in the same edge as any mask write or strobe.
- R2: A legal mask write for CPU c pulses post for each line whose summary bit goes from 0 to 1 and clear for each line whose summary bit goes from 1 to 0. It pulses nothing for any other line.
- R3: A raise strobe for line n sets pending bit n. It pulses post for line n to every CPU whose new mask has bit n set, even when line n was already pending.
- R4: A drop strobe for a pending line n clears pending bit n and pulses clear for line n to every CPU whose summary had bit n set.
- R5: A drop strobe for a line that is not pending leaves all state unchanged, produces no event, and pulses `spurious_clr` for one cycle.
- R6: When a raise and a drop strobe arrive in the same cycle, the drop is judged on the pending state before that cycle. If the dropped line was pending, it ends cleared. If it was not pending, the drop is spurious and the raise takes effect. So a raise and drop of the same pending line leave it cleared, and a raise and drop of the same idle line leave it set, with `spurious_clr` asserted.
- R7: The register index is `req_addr >> 6`; the low 6 address bits are ignored. The index map is:
  - index 0 is status;
  - indices 1 to 4 are the address-array window;
  - indices 8 to 11 are the masks of CPUs 0 to 3;
  - indices 16 to 19 are the summaries of CPUs 0 to 3;
  - index 24 is the pending vector.

  Status and the address-array window read as zero. The other registers read back their contents.
- R8: `req_size` encodes log2 of the access bytes, and only code 3 (8 bytes) is legal. Any other code sets `rsp_err`, returns zero data and changes no state.
- R9: A write to status, the address-array window, a summary or the pending vector, and any access to an unmapped index, sets `rsp_err`, returns zero data and changes no state.
- R10: `irq[c]` is the OR of all bits of CPU c's summary register.
- R11: Reset clears every mask, summary and pending bit and deasserts all outputs.
- R12: Every register access gives `rsp_valid` exactly one cycle later, with `rsp_rdata` and `rsp_err`. Events and `spurious_clr` appear in the cycle after the causing strobe or write and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_valid | input | 1 | Device raise strobe |
| raise_line | input | 6 | Line raised |
| clear_valid | input | 1 | Device drop strobe |
| clear_line | input | 6 | Line dropped |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Log2 of access bytes; 3 is legal |
| req_addr | input | 12 | Byte offset into register space |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Access response strobe |
| rsp_rdata | output | 64 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Access was illegal |
| spurious_clr | output | 1 | Drop strobe hit a non-pending line |
| irq | output | 4 | Per-CPU level interrupt |
| post_evt | output | 256 | Post pulses, bit c*64+n for CPU c, line n |
| clr_evt | output | 256 | Clear pulses, same layout |

## Verification
A summary that has drifted from mask AND pending shows on `irq` in the same cycle. It also shows as a wrong post or clear pulse on the next strobe or mask write that touches the affected line. It can also be read back directly over the register port one cycle after the read request. A pending bit lost or set wrongly shows up at the next drop of that line, which then pulses `spurious_clr` instead of clear, or the reverse. The sweeps therefore raise and drop every line against overlapping masks, re-read all state registers, and compare every event bit every cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int IDX_W = 6;
  localparam int IDX_STATUS = 0;
  localparam int IDX_WIN_LO = 1;
  localparam int IDX_WIN_HI = 4;
  localparam int IDX_MASK_BASE = 8;
  localparam int IDX_SUM_BASE = 16;
  localparam int IDX_PEND = 24;
  localparam logic [1:0] SIZE_DWORD = 2'd3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ZERO,
    SEL_MASK,
    SEL_SUM,
    SEL_PEND
  } reg_sel_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 12,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output reg_sel_e          sel,
  output logic [CPU_W-1:0]  cpu,
  output logic              acc_err,
  output logic              mask_we
);
  logic [IDX_W-1:0] idx;
  logic             size_ok;

  function automatic logic in_bank(input logic [IDX_W-1:0] i, input int base);
    return (int'(i) >= base) && (int'(i) < base + NUM_CPUS);
  endfunction

  assign idx     = IDX_W'(req_addr >> 6);
  assign size_ok = (req_size == SIZE_DWORD);

  always_comb begin
    sel = SEL_NONE;
    cpu = '0;
    if (int'(idx) == IDX_STATUS ||
        (int'(idx) >= IDX_WIN_LO && int'(idx) <= IDX_WIN_HI)) begin
      sel = SEL_ZERO;
    end else if (in_bank(idx, IDX_MASK_BASE)) begin
      sel = SEL_MASK;
      cpu = CPU_W'(int'(idx) - IDX_MASK_BASE);
    end else if (in_bank(idx, IDX_SUM_BASE)) begin
      sel = SEL_SUM;
      cpu = CPU_W'(int'(idx) - IDX_SUM_BASE);
    end else if (int'(idx) == IDX_PEND) begin
      sel = SEL_PEND;
    end
  end

  assign acc_err = req_valid &&
                   (!size_ok || sel == SEL_NONE || (req_write && sel != SEL_MASK));
  assign mask_we = req_valid && req_write && size_ok && (sel == SEL_MASK);
endmodule

// File: rtl/irq_route_cpu.sv
module irq_route_cpu #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] pend_next,
  input  logic [NUM_LINES-1:0] raise_vec,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] sum_q,
  output logic [NUM_LINES-1:0] post_q,
  output logic [NUM_LINES-1:0] clr_q
);
  logic [NUM_LINES-1:0] mask_d, sum_d;

  // Lines that newly became active, or were re-raised while enabled.
  function automatic logic [NUM_LINES-1:0] post_set(
      input logic [NUM_LINES-1:0] was, input logic [NUM_LINES-1:0] now,
      input logic [NUM_LINES-1:0] again);
    return now & (~was | again);
  endfunction

  // Lines that stopped being active.
  function automatic logic [NUM_LINES-1:0] drop_set(
      input logic [NUM_LINES-1:0] was, input logic [NUM_LINES-1:0] now);
    return was & ~now;
  endfunction

  assign mask_d = mask_we ? wdata : mask_q;
  assign sum_d  = mask_d & pend_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      sum_q  <= '0;
      post_q <= '0;
      clr_q  <= '0;
    end else begin
      mask_q <= mask_d;
      sum_q  <= sum_d;
      post_q <= post_set(sum_q, sum_d, raise_vec);
      clr_q  <= drop_set(sum_q, sum_d);
    end
  end
endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
  import irq_route_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int EVT_W    = NUM_CPUS * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 raise_valid,
  input  logic [LINE_W-1:0]    raise_line,
  input  logic                 clear_valid,
  input  logic [LINE_W-1:0]    clear_line,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [NUM_LINES-1:0] req_wdata,
  output logic                 rsp_valid,
  output logic [NUM_LINES-1:0] rsp_rdata,
  output logic                 rsp_err,
  output logic                 spurious_clr,
  output logic [NUM_CPUS-1:0]  irq,
  output logic [EVT_W-1:0]     post_evt,
  output logic [EVT_W-1:0]     clr_evt
);
  reg_sel_e             sel;
  logic [CPU_W-1:0]     cpu;
  logic                 acc_err, mask_we_any;
  logic [NUM_LINES-1:0] req_q, req_d, raise_vec, drop_vec;
  logic                 drop_hit;
  logic [NUM_LINES-1:0] mask_arr [NUM_CPUS];
  logic [NUM_LINES-1:0] sum_arr  [NUM_CPUS];
  logic [EVT_W-1:0]     mask_flat, sum_flat;
  logic [NUM_LINES-1:0] rd_d;

  irq_route_decode #(.NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .sel       (sel),
    .cpu       (cpu),
    .acc_err   (acc_err),
    .mask_we   (mask_we_any)
  );

  // Pending vector: raise first, then a drop judged on the old state.
  assign raise_vec = raise_valid ? (NUM_LINES'(1) << raise_line) : '0;
  assign drop_hit  = clear_valid && req_q[clear_line];
  assign drop_vec  = drop_hit ? (NUM_LINES'(1) << clear_line) : '0;
  assign req_d     = (req_q | raise_vec) & ~drop_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q        <= '0;
      spurious_clr <= 1'b0;
    end else begin
      req_q        <= req_d;
      spurious_clr <= clear_valid && !req_q[clear_line];
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic we_c;
    assign we_c = mask_we_any && (int'(cpu) == c);
    irq_route_cpu #(.NUM_LINES(NUM_LINES)) u_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_we   (we_c),
      .wdata     (req_wdata),
      .pend_next (req_d),
      .raise_vec (raise_vec),
      .mask_q    (mask_arr[c]),
      .sum_q     (sum_arr[c]),
      .post_q    (post_evt[c*NUM_LINES +: NUM_LINES]),
      .clr_q     (clr_evt[c*NUM_LINES +: NUM_LINES])
    );
    assign irq[c] = |sum_arr[c];
    assign mask_flat[c*NUM_LINES +: NUM_LINES] = mask_arr[c];
    assign sum_flat[c*NUM_LINES +: NUM_LINES]  = sum_arr[c];
  end

  always_comb begin
    rd_d = '0;
    if (req_valid && !req_write && !acc_err) begin
      case (sel)
        SEL_MASK: rd_d = mask_arr[cpu];
        SEL_SUM:  rd_d = sum_arr[cpu];
        SEL_PEND: rd_d = req_q;
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc_err;
      rsp_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_LINES = 64,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int EVT_W    = NUM_CPUS * NUM_LINES
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 raise_valid,
  input logic [LINE_W-1:0]    raise_line,
  input logic                 clear_valid,
  input logic [LINE_W-1:0]    clear_line,
  input logic                 req_valid,
  input logic [1:0]           req_size,
  input logic                 rsp_valid,
  input logic                 rsp_err,
  input logic                 spurious_clr,
  input logic [NUM_CPUS-1:0]  irq,
  input logic [EVT_W-1:0]     post_evt,
  input logic [EVT_W-1:0]     clr_evt,
  input logic [NUM_LINES-1:0] req_q,
  input logic [EVT_W-1:0]     mask_flat,
  input logic [EVT_W-1:0]     sum_flat
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
    p_sum_tracks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sum_flat[c*NUM_LINES +: NUM_LINES] == (mask_flat[c*NUM_LINES +: NUM_LINES] & req_q));
    p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] == (|sum_flat[c*NUM_LINES +: NUM_LINES]));
  end

  p_evt_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt & clr_evt) == '0);

  p_raise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    raise_valid && !(clear_valid && clear_line == raise_line) |=> req_q[$past(raise_line)]);

  p_drop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_valid && req_q[clear_line] |=> !req_q[$past(clear_line)] && !spurious_clr);

  p_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_valid && !req_q[clear_line] && !raise_valid |=> spurious_clr && $stable(req_q));

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_valid |=> !spurious_clr);

  p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size != 2'd3 |=> rsp_valid && rsp_err);

  p_rsp_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_err);
endmodule

bind irq_route_hub irq_route_chk #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/irq_route_hub_test.sv
`timescale 1ns/1ps
module irq_route_hub_test;
  localparam int NC = 4;
  localparam int NL = 64;
  localparam int EW = NC * NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          raise_valid = 1'b0, clear_valid = 1'b0;
  logic [5:0]    raise_line = '0, clear_line = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = '0;
  logic [11:0]   req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid, rsp_err, spurious_clr;
  logic [63:0]   rsp_rdata;
  logic [NC-1:0] irq;
  logic [EW-1:0] post_evt, clr_evt;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  logic [NL-1:0] mask_m [NC];
  logic [NL-1:0] old_sum [NC];
  logic [NL-1:0] req_m;
  logic [EW-1:0] exp_post, exp_clr;
  logic [NC-1:0] exp_irq;
  logic          exp_spur, exp_rv, exp_err;
  logic [63:0]   exp_rd;

  irq_route_hub uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic snap_old();
    for (int c = 0; c < NC; c++) old_sum[c] = mask_m[c] & req_m;
  endtask

  // Expected events from the requirement wording, line by line.
  task automatic calc_events(input bit rv, input int rl);
    for (int c = 0; c < NC; c++) begin
      exp_irq[c] = 1'b0;
      for (int l = 0; l < NL; l++) begin
        bit now_on, was_on;
        now_on = mask_m[c][l] && req_m[l];
        was_on = old_sum[c][l];
        if (now_on) exp_irq[c] = 1'b1;
        exp_post[c*NL + l] = now_on && (!was_on || (rv && rl == l));
        exp_clr[c*NL + l]  = was_on && !now_on;
      end
    end
  endtask

  task automatic finish_cycle(input string tag);
    @(negedge clk);
    chk(tag, "post_evt", post_evt, exp_post);
    chk(tag, "clr_evt", clr_evt, exp_clr);
    chk(tag, "irq(R10)", EW'(irq), EW'(exp_irq));
    chk(tag, "spurious_clr", EW'(spurious_clr), EW'(exp_spur));
    chk(tag, "rsp_valid(R12)", EW'(rsp_valid), EW'(exp_rv));
    chk(tag, "rsp_err", EW'(rsp_err), EW'(exp_err));
    chk(tag, "rsp_rdata", EW'(rsp_rdata), EW'(exp_rd));
    raise_valid = 0; clear_valid = 0; req_valid = 0; req_write = 0;
  endtask

  task automatic dev(input bit rv, input int rl, input bit cv, input int cl,
                     input string tag);
    bit was_pend;
    snap_old();
    was_pend = req_m[cl];
    if (rv) req_m[rl] = 1'b1;
    if (cv && was_pend) req_m[cl] = 1'b0;
    exp_spur = cv && !was_pend;
    calc_events(rv, rl);
    exp_rv = 0; exp_err = 0; exp_rd = '0;
    raise_valid = rv; raise_line = 6'(rl);
    clear_valid = cv; clear_line = 6'(cl);
    finish_cycle(tag);
  endtask

  task automatic reg_acc(input bit wr, input int idx, input logic [1:0] sz,
                         input logic [63:0] wd, input string tag);
    bit zero_r, is_mask, is_sum, is_pend;
    snap_old();
    zero_r  = (idx >= 0 && idx <= 4);
    is_mask = (idx >= 8 && idx < 8 + NC);
    is_sum  = (idx >= 16 && idx < 16 + NC);
    is_pend = (idx == 24);
    exp_err = (sz != 2'd3) || !(zero_r || is_mask || is_sum || is_pend) ||
              (wr && !is_mask);
    exp_rd = '0;
    if (!wr && !exp_err) begin
      if (is_mask) exp_rd = mask_m[idx-8];
      else if (is_sum) exp_rd = mask_m[idx-16] & req_m;
      else if (is_pend) exp_rd = req_m;
    end
    if (wr && !exp_err) mask_m[idx-8] = wd;
    calc_events(0, -1);
    exp_spur = 0; exp_rv = 1;
    req_valid = 1; req_write = wr; req_size = sz;
    req_addr = 12'(idx * 64 + 8); req_wdata = wd;
    finish_cycle(tag);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) mask_m[c] = '0;
    req_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    snap_old(); calc_events(0, -1);
    exp_spur = 0; exp_rv = 0; exp_err = 0; exp_rd = '0;
    finish_cycle("R11 reset idle");
    for (int i = 8; i < 12; i++) reg_acc(0, i, 2'd3, '0, "R11 mask zero");
    for (int i = 16; i < 20; i++) reg_acc(0, i, 2'd3, '0, "R11 sum zero");
    reg_acc(0, 24, 2'd3, '0, "R11 pend zero");

    reg_acc(1, 8,  2'd3, '1, "R2 mask0 no pend");
    reg_acc(1, 9,  2'd3, 64'h5555_5555_5555_5555, "R2 mask1 no pend");
    reg_acc(1, 10, 2'd3, 64'hAAAA_AAAA_AAAA_AAAA, "R2 mask2 no pend");
    reg_acc(1, 11, 2'd3, 64'h0, "R2 mask3 no pend");

    for (int l = 0; l < NL; l++) dev(1, l, 0, 0, "R3 raise sweep");
    dev(0, 0, 0, 0, "R12 pulse ends");
    dev(1, 5, 0, 0, "R3 raise again");

    for (int i = 8; i < 12; i++) reg_acc(0, i, 2'd3, '0, "R7 mask read");
    for (int i = 16; i < 20; i++) reg_acc(0, i, 2'd3, '0, "R1 sum read");
    reg_acc(0, 24, 2'd3, '0, "R7 pend read");
    for (int i = 0; i <= 4; i++) reg_acc(0, i, 2'd3, '0, "R7 zero regs");

    for (int l = 1; l < NL; l += 2) dev(0, 0, 1, l, "R4 drop odd");
    dev(0, 0, 1, 1, "R5 spurious drop");
    dev(0, 0, 0, 0, "R5 flag ends");
    reg_acc(0, 24, 2'd3, '0, "R5 pend unchanged");

    dev(1, 2, 1, 2, "R6 same pending line");
    dev(1, 3, 1, 3, "R6 same idle line");
    dev(1, 7, 1, 4, "R6 different lines");
    reg_acc(0, 24, 2'd3, '0, "R6 pend read");

    reg_acc(1, 11, 2'd3, '1, "R2 mask3 enable all");
    reg_acc(1, 8,  2'd3, '0, "R2 mask0 disable all");
    reg_acc(1, 9,  2'd3, 64'hF0F0_0F0F_FFFF_0000, "R2 mask1 mixed");
    reg_acc(1, 9,  2'd3, 64'hF0F0_0F0F_FFFF_0000, "R2 mask1 same value");
    for (int i = 16; i < 20; i++) reg_acc(0, i, 2'd3, '0, "R1 sum after masks");

    reg_acc(1, 10, 2'd2, '1, "R8 write size 4");
    reg_acc(0, 24, 2'd0, '0, "R8 read size 1");
    reg_acc(0, 10, 2'd3, '0, "R8 mask2 unchanged");

    reg_acc(1, 16, 2'd3, '1, "R9 write sum");
    reg_acc(1, 24, 2'd3, '0, "R9 write pend");
    reg_acc(1, 0,  2'd3, '1, "R9 write status");
    reg_acc(1, 2,  2'd3, '1, "R9 write window");
    reg_acc(0, 30, 2'd3, '0, "R9 read unmapped");
    reg_acc(1, 12, 2'd3, '1, "R9 write unmapped");
    reg_acc(0, 24, 2'd3, '0, "R9 pend unchanged");
    for (int i = 16; i < 20; i++) reg_acc(0, i, 2'd3, '0, "R9 sums unchanged");

    for (int l = 0; l < NL; l++) dev(0, 0, 1, l, "R4 drop all");
    dev(0, 0, 0, 0, "R10 all quiet");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule